// File: doc/BRIEF.md
# 8b/10b Character Encoder with Disparity Override

The encoder turns one character per clock into a 10-bit code group. A character is a byte plus a flag that says whether it is a control character. The byte is split into a low 5-bit part and a high 3-bit part, which are coded into a 6-bit and a 4-bit sub-block. The choice between the two complementary forms of a sub-block follows a running disparity that the block keeps and drives out on every cycle.

For each character the caller can leave the disparity alone, flip it, or force it to a given polarity. This lets a link controller lay down fixed comma patterns, for example two positive and then two negative commas. A control request for a byte outside the legal set raises an error flag for that cycle. In that case the encoder sends a comma and keeps its disparity state. A bypass input sends a raw 10-bit word out unchanged.

Top module: `enc8b10b_disp`

## Requirements
- R1: With `rst` high at a clock edge, the next cycle shows `codeOut` = 0, `kErr` = 0 and `rdOut` = 0, where 0 means negative running disparity.
- R2: Each output is registered. Inputs sampled at one rising edge appear on `codeOut`, `kErr` and `rdOut` right after that edge, and they do not change between edges.
- R3: When `kIn` is 0, `dataIn[4:0]` selects the 6-bit sub-block in `codeOut[9:4]` (bit 9 sent first) and `dataIn[7:5]` selects the 4-bit sub-block in `codeOut[3:0]`, using the standard 8b/10b data code. This includes the alternate x.7 form and the disparity-dependent forms of the 5-bit value 7 and the 3-bit value 3.
- R4: When `kIn` is 1, exactly twelve bytes are legal control characters: 1C, 3C, 5C, 7C, 9C, BC, DC, FC, F7, FB, FD and FE (hex). Each legal byte is coded as its standard control code group for the selected disparity.
- R5: When `kIn` is 1 and the byte is not legal, `kErr` is 1 for that character and `codeOut` is the comma 0011111010 (for negative disparity) or 1100000101 (for positive). `rdOut` keeps its previous value.
- R6: After a legal coded character, `rdOut` is 1 if the code group has six ones and 0 if it has four. A balanced group leaves `rdOut` at the disparity that was selected for that character.
- R7: The disparity selected for a character depends on {`dispMode`, `dispVal`}. With 00 the running value is used. With 01 the running value is inverted. With 1v the disparity is forced to v (1 = positive).
- R8: While `bypass` is 1, `codeOut` takes `rawIn` unchanged and `kErr` is 0. `rdOut` does not change, and `dataIn`, `kIn`, `dispMode` and `dispVal` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 8 | Character byte |
| kIn | input | 1 | Control-character request |
| rawIn | input | 10 | Raw code group used when bypassing |
| bypass | input | 1 | Pass `rawIn` through unchanged |
| dispMode | input | 1 | Disparity override mode |
| dispVal | input | 1 | Disparity override value |
| codeOut | output | 10 | Registered code group, bit 9 = a, bit 0 = j |
| kErr | output | 1 | Illegal control request for this character |
| rdOut | output | 1 | Running disparity, 1 = positive |

## Verification
The data characters are chosen so that each special case of the code shows up. There are unbalanced sub-blocks that must be complemented. There are balanced sub-blocks that must not be complemented, except for the 5-bit value 7 and the 3-bit value 3, which must flip. There are x.7 characters on both sides of the alternate-form boundary. Each of these is given at both disparities, so a wrong table entry and a wrong polarity rule produce different failures. Repeated commas with every override setting are checked against the four-comma pattern, which separates invert from force. Illegal bytes and bypass words are followed by characters whose code depends on the disparity that should have been kept, so a disparity change that should not happen shows up in a later code group.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
  localparam int BYTE_W    = 8;
  localparam int CODE_W    = 10;
  localparam int LOW_W     = 5;
  localparam int HIGH_W    = BYTE_W - LOW_W;
  localparam int SIX_W     = LOW_W + 1;
  localparam int FOUR_W    = HIGH_W + 1;
  localparam int K_LEGAL_N = 12;
  localparam int ONES_W    = $clog2(CODE_W + 1);

  localparam logic [CODE_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [CODE_W-1:0] COMMA_POS = 10'b1100000101;

  // Strobes from the disparity control to the coding datapath
  typedef struct packed {
    logic usePos;     // disparity chosen for this character
    logic sendComma;  // illegal control request: send a comma
    logic passRaw;    // bypass: send the raw word
  } encStrobe_t;
endpackage

// File: rtl/enc8b10b_ctrl.sv
module enc8b10b_ctrl
  import enc8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              kIn,
  input  logic              bypass,
  input  logic              dispMode,
  input  logic              dispVal,
  input  logic              codeHeavy,
  input  logic              codeLight,
  output encStrobe_t        strobe,
  output logic              rdOut,
  output logic              kErr
);
  localparam logic [BYTE_W-1:0] K_LIST [K_LEGAL_N] = '{
    8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
    8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE
  };

  logic [K_LEGAL_N-1:0] kHit;
  logic                 kLegal;
  logic                 selPos;
  logic                 rdReg;
  logic                 errReg;

  for (genvar gi = 0; gi < K_LEGAL_N; gi++) begin : gKMatch
    assign kHit[gi] = (dataIn == K_LIST[gi]);
  end
  assign kLegal = |kHit;

  always_comb begin
    case ({dispMode, dispVal})
      2'b00:   selPos = rdReg;
      2'b01:   selPos = ~rdReg;
      default: selPos = dispVal;
    endcase
  end

  always_comb begin
    strobe.usePos    = selPos;
    strobe.passRaw   = bypass;
    strobe.sendComma = !bypass && kIn && !kLegal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdReg  <= 1'b0;
      errReg <= 1'b0;
    end else begin
      errReg <= strobe.sendComma;
      if (strobe.passRaw || strobe.sendComma) rdReg <= rdReg;
      else if (codeHeavy)                     rdReg <= 1'b1;
      else if (codeLight)                     rdReg <= 1'b0;
      else                                    rdReg <= selPos;
    end
  end

  assign rdOut = rdReg;
  assign kErr  = errReg;

  AST_RD_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    kErr |-> (rdOut == $past(rdOut))); // R5
  AST_RD_HOLD_BYPASS: assert property (@(posedge clk) disable iff (rst)
    bypass |=> $stable(rdOut)); // R8
endmodule

// File: rtl/enc8b10b_datapath.sv
module enc8b10b_datapath
  import enc8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              kIn,
  input  logic [CODE_W-1:0] rawIn,
  input  encStrobe_t        strobe,
  output logic [CODE_W-1:0] codeOut,
  output logic              codeHeavy,
  output logic              codeLight
);
  localparam int HALF = CODE_W / 2;
  localparam logic [LOW_W-1:0] X_K28 = 5'd28;
  localparam logic [LOW_W-1:0] X_D7  = 5'd7;
  localparam logic [HIGH_W-1:0] Y_D3 = 3'd3;
  localparam logic [HIGH_W-1:0] Y_D7 = 3'd7;

  function automatic logic [ONES_W-1:0] countOnes(input logic [CODE_W-1:0] v);
    logic [ONES_W-1:0] n;
    n = '0;
    for (int i = 0; i < CODE_W; i++) n = n + ONES_W'(v[i]);
    return n;
  endfunction

  // 6-bit sub-block, negative-disparity form
  function automatic logic [SIX_W-1:0] base6(input logic [LOW_W-1:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // 4-bit sub-block, negative-disparity form (primary x.7)
  function automatic logic [FOUR_W-1:0] base4(input logic [HIGH_W-1:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  // 4-bit tail of K28.y, negative-disparity form
  function automatic logic [FOUR_W-1:0] k28Tail(input logic [HIGH_W-1:0] y);
    case (y)
      3'd0: return 4'b0100;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b0011;
      3'd4: return 4'b0010;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [SIX_W-1:0] pick6(input logic [LOW_W-1:0] x, input logic pos);
    logic [SIX_W-1:0] b;
    b = base6(x);
    if (pos && (countOnes(CODE_W'(b)) != ONES_W'(SIX_W / 2) || x == X_D7)) return ~b;
    return b;
  endfunction

  function automatic logic [FOUR_W-1:0] pick4(input logic [HIGH_W-1:0] y,
                                              input logic [LOW_W-1:0] x,
                                              input logic pos);
    logic [FOUR_W-1:0] b;
    logic useAlt;
    useAlt = pos ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                 : (x == 5'd17 || x == 5'd18 || x == 5'd20);
    if (y == Y_D7 && useAlt) return pos ? 4'b1000 : 4'b0111;
    b = base4(y);
    if (pos && (countOnes(CODE_W'(b)) != ONES_W'(FOUR_W / 2) || y == Y_D3)) return ~b;
    return b;
  endfunction

  logic [LOW_W-1:0]  xPart;
  logic [HIGH_W-1:0] yPart;
  logic [SIX_W-1:0]  sixSel;
  logic [ONES_W-1:0] sixOnes;
  logic              midPos;
  logic [CODE_W-1:0] kGroup;
  logic [CODE_W-1:0] nextCode;
  logic [ONES_W-1:0] nextOnes;
  logic [CODE_W-1:0] codeReg;
  logic              rawQ;
  logic              codeValid;

  always_comb begin
    xPart   = dataIn[LOW_W-1:0];
    yPart   = dataIn[BYTE_W-1:LOW_W];
    sixSel  = pick6(xPart, strobe.usePos);
    sixOnes = countOnes(CODE_W'(sixSel));
    if (sixOnes > ONES_W'(SIX_W / 2))      midPos = 1'b1;
    else if (sixOnes < ONES_W'(SIX_W / 2)) midPos = 1'b0;
    else                                   midPos = strobe.usePos;

    if (xPart == X_K28) begin
      kGroup = {6'b001111, k28Tail(yPart)};
      if (strobe.usePos) kGroup = ~kGroup;
    end else begin
      kGroup = {sixSel, strobe.usePos ? 4'b0111 : 4'b1000};
    end

    if (strobe.passRaw)        nextCode = rawIn;
    else if (strobe.sendComma) nextCode = strobe.usePos ? COMMA_POS : COMMA_NEG;
    else if (kIn)              nextCode = kGroup;
    else                       nextCode = {sixSel, pick4(yPart, xPart, midPos)};

    nextOnes  = countOnes(nextCode);
    codeHeavy = !strobe.passRaw && (nextOnes > ONES_W'(HALF));
    codeLight = !strobe.passRaw && (nextOnes < ONES_W'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codeReg   <= '0;
      rawQ      <= 1'b0;
      codeValid <= 1'b0;
    end else begin
      codeReg   <= nextCode;
      rawQ      <= strobe.passRaw;
      codeValid <= 1'b1;
    end
  end

  assign codeOut = codeReg;

  AST_CODE_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (codeValid && !rawQ) |-> (countOnes(codeOut) >= ONES_W'(HALF - 1) &&
                              countOnes(codeOut) <= ONES_W'(HALF + 1))); // R3
endmodule

// File: rtl/enc8b10b_disp.sv
module enc8b10b_disp
  import enc8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              kIn,
  input  logic [CODE_W-1:0] rawIn,
  input  logic              bypass,
  input  logic              dispMode,
  input  logic              dispVal,
  output logic [CODE_W-1:0] codeOut,
  output logic              kErr,
  output logic              rdOut
);
  encStrobe_t strobe;
  logic       codeHeavy;
  logic       codeLight;

  enc8b10b_ctrl uCtrl (
    .clk(clk), .rst(rst), .dataIn(dataIn), .kIn(kIn), .bypass(bypass),
    .dispMode(dispMode), .dispVal(dispVal), .codeHeavy(codeHeavy),
    .codeLight(codeLight), .strobe(strobe), .rdOut(rdOut), .kErr(kErr)
  );

  enc8b10b_datapath uPath (
    .clk(clk), .rst(rst), .dataIn(dataIn), .kIn(kIn), .rawIn(rawIn),
    .strobe(strobe), .codeOut(codeOut), .codeHeavy(codeHeavy), .codeLight(codeLight)
  );

  AST_ERR_COMMA: assert property (@(posedge clk) disable iff (rst)
    kErr |-> (codeOut == COMMA_NEG || codeOut == COMMA_POS)); // R5
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (codeOut == $past(rawIn) && !kErr)); // R8
  AST_RD_HEAVY: assert property (@(posedge clk) disable iff (rst)
    (!$past(bypass) && !kErr && $countones(codeOut) == 6) |-> rdOut); // R6
  AST_RD_LIGHT: assert property (@(posedge clk) disable iff (rst)
    (!$past(bypass) && !kErr && $countones(codeOut) == 4) |-> !rdOut); // R6
endmodule

// File: tb/tb_enc8b10b_disp.sv
module tb_enc8b10b_disp;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] dataIn;
  logic       kIn;
  logic [9:0] rawIn;
  logic       bypass;
  logic       dispMode;
  logic       dispVal;
  logic [9:0] codeOut;
  logic       kErr;
  logic       rdOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  enc8b10b_disp dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .kIn(kIn), .rawIn(rawIn),
    .bypass(bypass), .dispMode(dispMode), .dispVal(dispVal),
    .codeOut(codeOut), .kErr(kErr), .rdOut(rdOut)
  );

  // {req, data, k, mode, val, expCode, expRd, expErr}
  localparam int NV = 22;
  localparam logic [26:0] VEC [NV] = '{
    {4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 10'h274, 1'b0, 1'b0},
    {4'd3, 8'hB5, 1'b0, 1'b0, 1'b0, 10'h2AA, 1'b0, 1'b0},
    {4'd4, 8'hBC, 1'b1, 1'b0, 1'b0, 10'h0FA, 1'b1, 1'b0},
    {4'd4, 8'hBC, 1'b1, 1'b0, 1'b0, 10'h305, 1'b0, 1'b0},
    {4'd3, 8'hF1, 1'b0, 1'b0, 1'b0, 10'h237, 1'b1, 1'b0},
    {4'd3, 8'hEB, 1'b0, 1'b0, 1'b0, 10'h348, 1'b0, 1'b0},
    {4'd3, 8'h67, 1'b0, 1'b0, 1'b0, 10'h38C, 1'b0, 1'b0},
    {4'd3, 8'h37, 1'b0, 1'b0, 1'b0, 10'h3A9, 1'b1, 1'b0},
    {4'd3, 8'h67, 1'b0, 1'b0, 1'b0, 10'h073, 1'b1, 1'b0},
    {4'd4, 8'hF7, 1'b1, 1'b0, 1'b0, 10'h057, 1'b1, 1'b0},
    {4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 10'h305, 1'b1, 1'b1},
    {4'd7, 8'hBC, 1'b1, 1'b0, 1'b0, 10'h305, 1'b0, 1'b0},
    {4'd7, 8'hBC, 1'b1, 1'b0, 1'b1, 10'h305, 1'b0, 1'b0},
    {4'd7, 8'hBC, 1'b1, 1'b0, 1'b0, 10'h0FA, 1'b1, 1'b0},
    {4'd7, 8'hBC, 1'b1, 1'b0, 1'b1, 10'h0FA, 1'b1, 1'b0},
    {4'd7, 8'h00, 1'b0, 1'b1, 1'b0, 10'h274, 1'b0, 1'b0},
    {4'd7, 8'h00, 1'b0, 1'b1, 1'b1, 10'h18B, 1'b1, 1'b0},
    {4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 10'h18B, 1'b1, 1'b0},
    {4'd4, 8'hFC, 1'b1, 1'b0, 1'b0, 10'h307, 1'b1, 1'b0},
    {4'd4, 8'h1C, 1'b1, 1'b0, 1'b0, 10'h30B, 1'b1, 1'b0},
    {4'd5, 8'hBD, 1'b1, 1'b0, 1'b0, 10'h305, 1'b1, 1'b1},
    {4'd4, 8'hFE, 1'b1, 1'b0, 1'b0, 10'h217, 1'b1, 1'b0}
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishUp;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finishUp();
  end

  initial begin
    rst = 1'b1; dataIn = '0; kIn = 1'b0; rawIn = '0;
    bypass = 1'b0; dispMode = 1'b0; dispVal = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset code", codeOut, 10'h000);
    check("R1", "reset kErr", {9'b0, kErr}, 10'd0);
    check("R1", "reset rd", {9'b0, rdOut}, 10'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      dataIn = v[22:15]; kIn = v[14]; dispMode = v[13]; dispVal = v[12];
      @(negedge clk);
      check(reqName(v[26:23]), $sformatf("vector %0d code", i), codeOut, v[11:2]);
      check("R6", $sformatf("vector %0d rd", i), {9'b0, rdOut}, {9'b0, v[1]});
      check("R5", $sformatf("vector %0d kErr", i), {9'b0, kErr}, {9'b0, v[0]});
    end

    // R2: output holds between edges, then updates after the edge (rd positive here)
    dataIn = 8'hB5; kIn = 1'b0; dispMode = 1'b0; dispVal = 1'b0;
    #5;
    check("R2", "hold before edge", codeOut, 10'h217);
    @(negedge clk);
    check("R2", "update after edge", codeOut, 10'h2AA);

    // R8: bypass with an illegal K request and a force that would change rd
    bypass = 1'b1; rawIn = 10'h155; dataIn = 8'h00; kIn = 1'b1;
    dispMode = 1'b1; dispVal = 1'b0;
    @(negedge clk);
    check("R8", "bypass code", codeOut, 10'h155);
    check("R8", "bypass kErr", {9'b0, kErr}, 10'd0);
    check("R8", "bypass rd", {9'b0, rdOut}, 10'd1);
    rawIn = 10'h3E0;
    @(negedge clk);
    check("R8", "bypass code 2", codeOut, 10'h3E0);
    // disparity kept through bypass: D0.0 normal must use the positive form
    bypass = 1'b0; kIn = 1'b0; dispMode = 1'b0;
    @(negedge clk);
    check("R8", "rd kept after bypass", codeOut, 10'h18B);

    // R1: reset in mid-run from positive disparity
    rst = 1'b1;
    @(negedge clk);
    check("R1", "mid reset code", codeOut, 10'h000);
    check("R1", "mid reset rd", {9'b0, rdOut}, 10'd0);
    rst = 1'b0;
    dataIn = 8'hBC; kIn = 1'b1;
    @(negedge clk);
    check("R1", "negative after reset", codeOut, 10'h0FA);
    finishUp();
  end
endmodule